// File: doc/BRIEF.md
# Sequenced Trigger Unit

This block watches a stream of 32-channel samples and raises a single-cycle trigger pulse once a programmed chain of conditions has been met in order. Four stages each hold a channel mask, a compare value, an edge-select word and a control word. The control word gives the stage its sequence level and may carry a fire flag. A shared level counter decides which stages are live. A stage is tested only while the counter equals its level. A live stage that matches without the fire flag moves the counter up by one. A live stage that matches with the fire flag raises the trigger.

Per channel, a stage can require a low level, a high level, a rising edge or a falling edge. A masked channel compares the sample bit with the value bit. If its edge bit is also set, the channel must additionally have toggled since the previous qualified sample, so value 1 means rising and value 0 means falling. Unused stages are parked at the top level with empty masks and no fire flag. An arm pulse restarts the sequence before each capture.

Top module: `seqtrig_top`

## Requirements
- R1: After synchronous reset, trig_o is 0, the level counter is 0, the unit is not fired, the previous-sample register is 0, and every stage register is 0.
- R2: A write with cfg_we=1 stores cfg_wdata into stage cfg_stage. The field is chosen by cfg_sel: 0 mask, 1 value, 2 edge, 3 control. In the control word, bits [17:16] hold the stage level and bit 27 is the fire flag.
- R3: A live stage meets its level condition when ((sample XOR value) AND mask) is zero.
- R4: For each channel that is set in both mask and edge, the sample bit must also differ from the previous qualified sample.
- R5: A stage is evaluated only while the level counter equals its level field.
- R6: A sample on which a live stage without the fire flag matches, and no live stage with the fire flag matches, increments the level counter by exactly one. The counter saturates at 3.
- R7: A sample on which a live stage with the fire flag matches drives trig_o high for exactly one cycle, on the cycle after that sample.
- R8: After firing, the unit produces no further pulse and does not move the level counter until it is armed again.
- R9: arm clears the level counter and the fired state. The sample presented in the arm cycle is not evaluated, but it still becomes the previous sample.
- R10: Cycles with smp_valid low have no effect. Nothing matches, and the previous-sample register is not updated.
- R11: A disabled stage (zero mask, value and edge, level 3, no fire flag) does not disturb a sequence built on the other stages.
- R12: Stage 0 with an all-zero mask, level 0 and the fire flag triggers on the first qualified sample after arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Stage register write strobe |
| cfg_stage | input | 2 | Stage index for the write |
| cfg_sel | input | 2 | Field select: 0 mask, 1 value, 2 edge, 3 control |
| cfg_wdata | input | 32 | Write data |
| arm | input | 1 | Restart the sequence (run command) |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 32 | Sample word |
| trig_o | output | 1 | Registered single-cycle trigger pulse |

## Verification
The bench builds the unit with its defaults: 32 channels, four stages and a two-bit level counter. With these settings, level saturation at 3 and the parked-stage arrangement are reachable exactly as they are programmed in use. Random stage programs keep masks and samples within the low nibble. This makes level and edge matches common enough to drive multi-step sequences, simultaneous live stages and post-fire quiet periods. Directed cases cover the immediate-fire setup, arm in the same cycle as a sample, and gaps of invalid samples between edges.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;
  localparam int CTL_LVL_LSB   = 16;
  localparam int CTL_FIRE_BIT  = 27;
  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_EDGE  = 2'd2,
    SEL_CTL   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/seqtrig_regs.sv
module seqtrig_regs #(
  parameter int CH_W   = 32,
  parameter int STAGES = 4,
  parameter int LVL_W  = 2,
  localparam int SI_W  = $clog2(STAGES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [SI_W-1:0]                   stage,
  input  logic [1:0]                        sel,
  input  logic [CH_W-1:0]                   wdata,
  output logic [STAGES-1:0][CH_W-1:0]       mask_q,
  output logic [STAGES-1:0][CH_W-1:0]       value_q,
  output logic [STAGES-1:0][CH_W-1:0]       edge_q,
  output logic [STAGES-1:0][LVL_W-1:0]      lvl_q,
  output logic [STAGES-1:0]                 fire_q
);
  import seqtrig_pkg::*;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[s]  <= '0;
        value_q[s] <= '0;
        edge_q[s]  <= '0;
        lvl_q[s]   <= '0;
        fire_q[s]  <= 1'b0;
      end else if (we && stage == SI_W'(s)) begin
        case (cfg_sel_e'(sel))
          SEL_MASK:  mask_q[s]  <= wdata;
          SEL_VALUE: value_q[s] <= wdata;
          SEL_EDGE:  edge_q[s]  <= wdata;
          default: begin
            lvl_q[s]  <= wdata[CTL_LVL_LSB +: LVL_W];
            fire_q[s] <= wdata[CTL_FIRE_BIT];
          end
        endcase
      end
    end
  end

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd0) |=> (mask_q[$past(stage)] == $past(wdata)));
endmodule

// File: rtl/seqtrig_match.sv
module seqtrig_match #(
  parameter int CH_W  = 32,
  parameter int LVL_W = 2
) (
  input  logic [CH_W-1:0]  mask,
  input  logic [CH_W-1:0]  value,
  input  logic [CH_W-1:0]  edge_sel,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [CH_W-1:0]  smp,
  input  logic [CH_W-1:0]  prev,
  output logic             hit
);
  logic [CH_W-1:0] need_toggle;
  logic            lvl_ok, edge_ok, live;

  always_comb begin
    need_toggle = mask & edge_sel;
    lvl_ok      = ((smp ^ value) & mask) == '0;
    edge_ok     = ((smp ^ prev) & need_toggle) == need_toggle;
    live        = (lvl == cur_lvl);
    hit         = live && lvl_ok && edge_ok;
  end
endmodule

// File: rtl/seqtrig_ctrl.sv
module seqtrig_ctrl #(
  parameter int CH_W   = 32,
  parameter int STAGES = 4,
  parameter int LVL_W  = 2,
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_data,
  input  logic [STAGES-1:0] hit,
  input  logic [STAGES-1:0] fire,
  output logic [LVL_W-1:0]  cur_lvl,
  output logic [CH_W-1:0]   prev,
  output logic              trig_o
);
  logic fired;
  logic any_fire, any_adv, eval;

  always_comb begin
    eval     = smp_valid && !arm && !fired;
    any_fire = |(hit & fire);
    any_adv  = |(hit & ~fire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl <= '0;
      fired   <= 1'b0;
      trig_o  <= 1'b0;
      prev    <= '0;
    end else begin
      trig_o <= 1'b0;
      if (smp_valid) prev <= smp_data;
      if (arm) begin
        cur_lvl <= '0;
        fired   <= 1'b0;
      end else if (eval) begin
        if (any_fire) begin
          trig_o <= 1'b1;
          fired  <= 1'b1;
        end else if (any_adv && cur_lvl != LVL_TOP) begin
          cur_lvl <= cur_lvl + 1'b1;
        end
      end
    end
  end

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);
  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_o) |-> $past(smp_valid) && !$past(arm));
  // R8
  quiet_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (fired && !arm) |=> (!trig_o && $stable(cur_lvl)));
  // R9
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (cur_lvl == '0 && !fired && !trig_o));
  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !arm) |=> ($stable(cur_lvl) && $stable(prev) && !trig_o));
  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm) |=> (cur_lvl == $past(cur_lvl) || cur_lvl == $past(cur_lvl) + 1'b1));
endmodule

// File: rtl/seqtrig_top.sv
module seqtrig_top #(
  parameter int CH_W   = 32,
  parameter int STAGES = 4,
  parameter int LVL_W  = 2,
  localparam int SI_W  = $clog2(STAGES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SI_W-1:0] cfg_stage,
  input  logic [1:0]      cfg_sel,
  input  logic [CH_W-1:0] cfg_wdata,
  input  logic            arm,
  input  logic            smp_valid,
  input  logic [CH_W-1:0] smp_data,
  output logic            trig_o
);
  logic [STAGES-1:0][CH_W-1:0]  mask_q, value_q, edge_q;
  logic [STAGES-1:0][LVL_W-1:0] lvl_q;
  logic [STAGES-1:0]            fire_q, hit;
  logic [LVL_W-1:0]             cur_lvl;
  logic [CH_W-1:0]              prev;

  seqtrig_regs #(.CH_W(CH_W), .STAGES(STAGES), .LVL_W(LVL_W)) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .stage(cfg_stage), .sel(cfg_sel),
    .wdata(cfg_wdata), .mask_q(mask_q), .value_q(value_q), .edge_q(edge_q),
    .lvl_q(lvl_q), .fire_q(fire_q)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_match
    seqtrig_match #(.CH_W(CH_W), .LVL_W(LVL_W)) i_match (
      .mask(mask_q[s]), .value(value_q[s]), .edge_sel(edge_q[s]),
      .lvl(lvl_q[s]), .cur_lvl(cur_lvl), .smp(smp_data), .prev(prev),
      .hit(hit[s])
    );
  end

  seqtrig_ctrl #(.CH_W(CH_W), .STAGES(STAGES), .LVL_W(LVL_W)) i_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .hit(hit), .fire(fire_q), .cur_lvl(cur_lvl),
    .prev(prev), .trig_o(trig_o)
  );
endmodule

// File: tb/test_seqtrig_top.sv
module test_seqtrig_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_stage = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        trig_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_mask [4];
  logic [31:0] m_val  [4];
  logic [31:0] m_edge [4];
  logic [1:0]  m_lvl  [4];
  logic        m_fire [4];
  logic [1:0]  m_cur;
  logic        m_fired;
  logic [31:0] m_prev;

  always #10 clk = ~clk;

  seqtrig_top i_seqtrig_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .arm(arm),
    .smp_valid(smp_valid), .smp_data(smp_data), .trig_o(trig_o)
  );

  function automatic bit model_hit(int s, logic [31:0] d);
    logic [31:0] tg;
    tg = m_mask[s] & m_edge[s];
    return (m_lvl[s] == m_cur) && (((d ^ m_val[s]) & m_mask[s]) == 0)
           && (((d ^ m_prev) & tg) == tg);
  endfunction

  function automatic bit model_step(bit a, bit v, logic [31:0] d);
    bit f, adv, t;
    t = 1'b0; f = 1'b0; adv = 1'b0;
    if (a) begin
      m_cur = 2'd0; m_fired = 1'b0;
    end else if (v && !m_fired) begin
      for (int s = 0; s < 4; s++) begin
        if (model_hit(s, d)) begin
          if (m_fire[s]) f = 1'b1; else adv = 1'b1;
        end
      end
      if (f) begin t = 1'b1; m_fired = 1'b1; end
      else if (adv && m_cur != 2'd3) m_cur = m_cur + 2'd1;
    end
    if (v) m_prev = d;
    return t;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int s, int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stage = 2'(s); cfg_sel = 2'(sel); cfg_wdata = d;
    case (sel)
      0: m_mask[s] = d;
      1: m_val[s] = d;
      2: m_edge[s] = d;
      default: begin m_lvl[s] = d[17:16]; m_fire[s] = d[27]; end
    endcase
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic prog(int s, logic [31:0] mk, logic [31:0] vl, logic [31:0] ed,
                      int lvl, bit fire);
    wr(s, 0, mk); wr(s, 1, vl); wr(s, 2, ed);
    wr(s, 3, (32'(fire) << 27) | (32'(lvl & 3) << 16));
  endtask

  task automatic disable_stage(int s);
    prog(s, 0, 0, 0, 3, 1'b0);
  endtask

  task automatic step(string tag, bit a, bit v, logic [31:0] d);
    bit e;
    @(negedge clk);
    arm = a; smp_valid = v; smp_data = d;
    e = model_step(a, v, d);
    @(posedge clk); #1;
    check(tag, trig_o, e);
    arm = 1'b0; smp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 4; s++) begin
      m_mask[s] = 0; m_val[s] = 0; m_edge[s] = 0; m_lvl[s] = 0; m_fire[s] = 0;
    end
    m_cur = 0; m_fired = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state; all stages zero, level 0 match advances only
    check("R1", trig_o, 1'b0);
    step("R1", 1'b0, 1'b1, 32'h5);

    // R12: immediate fire
    prog(0, 0, 0, 0, 0, 1'b1);
    for (int s = 1; s < 4; s++) disable_stage(s);
    step("R12", 1'b1, 1'b0, 0);
    step("R12", 1'b0, 1'b1, 32'hABCD);
    // R8: no repeat
    step("R8", 1'b0, 1'b1, 32'hABCD);
    step("R8", 1'b0, 1'b1, 32'h0);
    // R9: arm cycle sample not evaluated
    step("R9", 1'b1, 1'b1, 32'h1);
    step("R9", 1'b0, 1'b1, 32'h1);

    // R11 R5 R3: two-stage sequence, stages 2,3 parked
    prog(0, 32'hF, 32'h3, 0, 0, 1'b0);
    prog(1, 32'hF0, 32'h50, 0, 1, 1'b1);
    step("R11", 1'b1, 1'b0, 0);
    step("R5", 1'b0, 1'b1, 32'h50);
    step("R3", 1'b0, 1'b1, 32'h13);
    step("R10", 1'b0, 1'b0, 32'h50);
    step("R11", 1'b0, 1'b1, 32'h53);

    // R4: rising edge on bit 0 at stage 0 with fire
    prog(0, 32'h1, 32'h1, 32'h1, 0, 1'b1);
    step("R4", 1'b1, 1'b1, 32'h1);
    step("R4", 1'b0, 1'b1, 32'h1);
    step("R10", 1'b0, 1'b0, 32'h0);
    step("R4", 1'b0, 1'b1, 32'h1);
    step("R4", 1'b0, 1'b1, 32'h0);
    step("R4", 1'b0, 1'b1, 32'h1);

    // R6: saturation, all stages level-only, fire on level 3
    prog(0, 0, 0, 0, 0, 1'b0);
    prog(1, 0, 0, 0, 1, 1'b0);
    prog(2, 0, 0, 0, 2, 1'b0);
    prog(3, 32'h2, 32'h2, 0, 3, 1'b1);
    step("R6", 1'b1, 1'b0, 0);
    for (int i = 0; i < 5; i++) step("R6", 1'b0, 1'b1, 32'h0);
    step("R7", 1'b0, 1'b1, 32'h2);
    step("R7", 1'b0, 1'b0, 32'h2);

    // R2 R3 R4 R5 R6 R7 R8: random programs
    for (int it = 0; it < 400; it++) begin
      for (int s = 0; s < 4; s++) begin
        prog(s, $urandom & 32'hF, $urandom & 32'hF, $urandom & 32'h3,
             int'($urandom % 4), ($urandom % 4) == 0);
      end
      step("R9", 1'b1, 1'b0, 0);
      for (int k = 0; k < 24; k++)
        step("R2", 1'b0, ($urandom % 5) != 0, $urandom & 32'hF);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule